// File: doc/BRIEF.md
# Three-Level Compression Metadata Table Walker

The block turns a 48-bit main-surface virtual address into the address of the compression metadata that belongs to it, along with the attribute fields stored next to that address. To do this it walks a three-level table in memory. A root register holds the base of the top table. Each level is an array of 64-bit entries, and the block reads one entry per level through a simple read port with valid/ready handshakes. A response carries the metadata address, the format, plane, depth and tile-mode fields, a fault flag and an attribute-error flag.

There are two granularity modes, and a configuration input picks one. In fine mode one leaf entry covers 64 KB of main surface, and the leaf table has 256 entries. In coarse mode one leaf entry covers 1 MB, and the leaf table has 16 entries. Metadata is 1/256 the size of the main surface, so the page offset divided by 256 is added to the leaf pointer. An invalidate pulse cancels whatever walk is running. If a read was still outstanding when the walk was cancelled, its data is absorbed and thrown away before a new request is taken.

The control is an eight-state machine:

- `ST_IDLE` waits for a request.
- `ST_ISSUE_TOP`, `ST_ISSUE_MID` and `ST_ISSUE_LEAF` present a read.
- `ST_WAIT_TOP`, `ST_WAIT_MID` and `ST_WAIT_LEAF` take the returned entry.
- `ST_REPLY` holds the response.

The transitions are:

- Accepting a request moves from idle to issue-top.
- A read handshake moves each issue state to its wait state.
- A valid entry moves wait-top to issue-mid, and wait-mid to issue-leaf.
- An entry with the valid bit clear, or any leaf entry, moves a wait state to reply.
- A response handshake moves reply to idle.
- Invalidate moves every non-idle state to idle.

Top module: `meta_table_walker`

## Requirements
- R1: The top entry is read at root + addr[47:36]×8, the middle entry at its table pointer + addr[35:24]×8, and the leaf entry at its table pointer + leaf index×8.
- R2: A top entry gives the middle-table pointer as its bits 47:15 with bits 14:0 zero. A middle entry gives the leaf-table pointer as its bits 47:13 with bits 12:0 zero. All other entry bits except bit 0 are ignored.
- R3: Fine mode (mode_coarse=0) takes the leaf index from addr[23:16]. Coarse mode (mode_coarse=1) takes it from addr[23:20]. The mode is sampled only when the request is accepted.
- R4: Bit 0 of every entry is its valid bit. If it is clear at any level, no further read is issued and the response has rsp_fault=1, with zero metadata address, zero attributes and rsp_attr_err=0.
- R5: The metadata address is {leaf entry[47:8], 8'h00} plus the page offset shifted right by 8. The page offset is addr[15:0] in fine mode and addr[19:0] in coarse mode.
- R6: The leaf attributes are: format = entry[63:58], chroma = entry[57] (0 luma, 1 chroma), depth = entry[56:54], tile = entry[53:52].
- R7: A valid leaf with tile mode 2 or 3 sets rsp_attr_err. The metadata address is still returned.
- R8: Reads go out one at a time, in top, middle, leaf order. A read request is held stable until accepted. req_ready is high only in idle.
- R9: rsp_valid and every response field stay unchanged until rsp_ready is seen.
- R10: Invalidate returns the block to idle with no response. This includes when it coincides with the leaf data returning or with a held response.
- R11: A read still outstanding at invalidate is accepted later and discarded. req_ready stays low until that read has returned.
- R12: root_wr loads root_wdata into the root register. A walk uses the root value that was held when its request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_coarse | input | 1 | Granularity: 0 = 64 KB pages, 1 = 1 MB pages |
| root_wr | input | 1 | Load strobe for the root register |
| root_wdata | input | 48 | New root table base |
| invalidate | input | 1 | Cancel any walk or pending response |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_va | input | 48 | Main-surface virtual address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_meta_addr | output | 48 | Metadata address (zero on fault) |
| rsp_fault | output | 1 | An entry on the path had its valid bit clear |
| rsp_attr_err | output | 1 | Reserved tile mode in the leaf |
| rsp_format | output | 6 | Leaf format code |
| rsp_chroma | output | 1 | Leaf plane select |
| rsp_depth | output | 3 | Leaf depth code |
| rsp_tile | output | 2 | Leaf tile mode |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 48 | Byte address of the 64-bit entry |
| rd_rsp_valid | input | 1 | Memory read data valid |
| rd_rsp_ready | output | 1 | Read data accepted |
| rd_rsp_data | input | 64 | Entry read from memory |

## Verification
The case most likely to go wrong is an invalidate that arrives in the same cycle as a table entry returning from memory. Two outcomes must not both happen. Either the entry is consumed as part of the cancelled walk and no drain is needed, or it is still outstanding and must be absorbed later. The memory model in the bench pulses invalidate on the exact cycle it delivers the leaf data, which tests the first case. It also pulses invalidate one cycle after accepting a middle-level read with a long latency, which tests the second case. In both cases the bench checks three things: no response appears, req_ready stays low while the stale read is outstanding, and the following walk returns the correct address after exactly three reads.

// File: rtl/meta_walk_pkg.sv
package meta_walk_pkg;
    // Address and entry geometry
    localparam int VA_W            = 48;
    localparam int ENT_W           = 64;
    localparam int ENT_LOG         = 3;
    localparam int UP_IDX_W        = 12;
    localparam int TOP_LSB         = 36;
    localparam int MID_LSB         = 24;

    // Granularity variants: index 0 = fine (64 KB), 1 = coarse (1 MB)
    localparam int NUM_GRAN        = 2;
    localparam int FINE_PAGE_LOG   = 16;
    localparam int COARSE_PAGE_LOG = 20;
    localparam int LEAF_IDX_MAX_W  = MID_LSB - FINE_PAGE_LOG;
    localparam int RATIO_LOG       = 8;

    // Pointer fields inside entries
    localparam int MID_PTR_LSB     = 15;
    localparam int LEAF_PTR_LSB    = 13;
    localparam int META_PTR_LSB    = 8;
    localparam int VALID_BIT       = 0;

    // Leaf attribute fields
    localparam int FMT_LSB         = 58;
    localparam int FMT_W           = 6;
    localparam int PLANE_BIT       = 57;
    localparam int DEPTH_LSB       = 54;
    localparam int DEPTH_W         = 3;
    localparam int TILE_LSB        = 52;
    localparam int TILE_W          = 2;

    function automatic int page_log(input int g);
        return (g == 0) ? FINE_PAGE_LOG : COARSE_PAGE_LOG;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_TOP,
        ST_WAIT_TOP,
        ST_ISSUE_MID,
        ST_WAIT_MID,
        ST_ISSUE_LEAF,
        ST_WAIT_LEAF,
        ST_REPLY
    } walk_state_e;

    typedef enum logic [1:0] {
        LVL_TOP,
        LVL_MID,
        LVL_LEAF
    } walk_level_e;

    typedef struct packed {
        logic [FMT_W-1:0]   fmt;
        logic               chroma;
        logic [DEPTH_W-1:0] depth;
        logic [TILE_W-1:0]  tile;
    } leaf_attr_t;
endpackage

// File: rtl/mwalk_index.sv
// Splits the virtual address into per-level indices and the scaled page
// offset; one generate branch per granularity variant.
module mwalk_index
    import meta_walk_pkg::*;
(
    input  logic [VA_W-1:0]           va,
    input  logic                      coarse,
    output logic [UP_IDX_W-1:0]       top_idx,
    output logic [UP_IDX_W-1:0]       mid_idx,
    output logic [LEAF_IDX_MAX_W-1:0] leaf_idx,
    output logic [VA_W-1:0]           meta_off
);
    logic [LEAF_IDX_MAX_W-1:0] leaf_cand [NUM_GRAN];
    logic [VA_W-1:0]           off_cand  [NUM_GRAN];
    logic                      unused_low;

    assign top_idx    = va[TOP_LSB +: UP_IDX_W];
    assign mid_idx    = va[MID_LSB +: UP_IDX_W];
    assign unused_low = ^va[RATIO_LOG-1:0];

    for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
        localparam int PLOG = page_log(g);
        assign leaf_cand[g] = LEAF_IDX_MAX_W'(va[MID_LSB-1:PLOG]);
        assign off_cand[g]  = VA_W'(va[PLOG-1:RATIO_LOG]);
    end

    assign leaf_idx = leaf_cand[coarse];
    assign meta_off = off_cand[coarse];
endmodule

// File: rtl/mwalk_addr.sv
// Entry byte address for the level being read.
module mwalk_addr
    import meta_walk_pkg::*;
(
    input  walk_level_e               lvl,
    input  logic [VA_W-1:0]           tbl_ptr,
    input  logic [UP_IDX_W-1:0]       top_idx,
    input  logic [UP_IDX_W-1:0]       mid_idx,
    input  logic [LEAF_IDX_MAX_W-1:0] leaf_idx,
    output logic [VA_W-1:0]           ent_addr
);
    logic [UP_IDX_W-1:0] sel_idx;

    always_comb begin
        unique case (lvl)
            LVL_TOP:  sel_idx = top_idx;
            LVL_MID:  sel_idx = mid_idx;
            LVL_LEAF: sel_idx = UP_IDX_W'(leaf_idx);
            default:  sel_idx = '0;
        endcase
    end

    assign ent_addr = tbl_ptr + (VA_W'(sel_idx) << ENT_LOG);
endmodule

// File: rtl/mwalk_decode.sv
// Field extraction from a returned 64-bit table entry.
module mwalk_decode
    import meta_walk_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    output logic             present,
    output logic [VA_W-1:0]  mid_tbl,
    output logic [VA_W-1:0]  leaf_tbl,
    output logic [VA_W-1:0]  meta_base,
    output leaf_attr_t       attr,
    output logic             tile_bad
);
    logic unused_ent;

    assign present   = ent[VALID_BIT];
    assign mid_tbl   = {ent[VA_W-1:MID_PTR_LSB],  {MID_PTR_LSB{1'b0}}};
    assign leaf_tbl  = {ent[VA_W-1:LEAF_PTR_LSB], {LEAF_PTR_LSB{1'b0}}};
    assign meta_base = {ent[VA_W-1:META_PTR_LSB], {META_PTR_LSB{1'b0}}};

    assign attr.fmt    = ent[FMT_LSB +: FMT_W];
    assign attr.chroma = ent[PLANE_BIT];
    assign attr.depth  = ent[DEPTH_LSB +: DEPTH_W];
    assign attr.tile   = ent[TILE_LSB +: TILE_W];

    // Tile codes 2 and 3 are reserved
    assign tile_bad = attr.tile[TILE_W-1];

    assign unused_ent = ^{ent[TILE_LSB-1:VA_W], ent[META_PTR_LSB-1:VALID_BIT+1]};
endmodule

// File: rtl/meta_table_walker.sv
module meta_table_walker
    import meta_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_coarse,
    input  logic             root_wr,
    input  logic [47:0]      root_wdata,
    input  logic             invalidate,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [47:0]      req_va,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [47:0]      rsp_meta_addr,
    output logic             rsp_fault,
    output logic             rsp_attr_err,
    output logic [5:0]       rsp_format,
    output logic             rsp_chroma,
    output logic [2:0]       rsp_depth,
    output logic [1:0]       rsp_tile,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [47:0]      rd_req_addr,
    input  logic             rd_rsp_valid,
    output logic             rd_rsp_ready,
    input  logic [63:0]      rd_rsp_data
);
    walk_state_e state_q, state_d;

    logic [VA_W-1:0] root_q;
    logic [VA_W-1:0] va_q;
    logic            coarse_q;
    logic [VA_W-1:0] tbl_ptr_q;
    logic            drop_q;

    logic [VA_W-1:0] meta_q;
    logic            fault_q;
    logic            attr_err_q;
    leaf_attr_t      attr_q;

    // Index split
    logic [UP_IDX_W-1:0]       top_idx, mid_idx;
    logic [LEAF_IDX_MAX_W-1:0] leaf_idx;
    logic [VA_W-1:0]           meta_off;

    mwalk_index u_index (
        .va       (va_q),
        .coarse   (coarse_q),
        .top_idx  (top_idx),
        .mid_idx  (mid_idx),
        .leaf_idx (leaf_idx),
        .meta_off (meta_off)
    );

    // Entry address
    walk_level_e lvl;

    mwalk_addr u_addr (
        .lvl      (lvl),
        .tbl_ptr  (tbl_ptr_q),
        .top_idx  (top_idx),
        .mid_idx  (mid_idx),
        .leaf_idx (leaf_idx),
        .ent_addr (rd_req_addr)
    );

    // Entry decode
    logic            dec_present;
    logic [VA_W-1:0] dec_mid_tbl, dec_leaf_tbl, dec_meta_base;
    leaf_attr_t      dec_attr;
    logic            dec_tile_bad;

    mwalk_decode u_decode (
        .ent       (rd_rsp_data),
        .present   (dec_present),
        .mid_tbl   (dec_mid_tbl),
        .leaf_tbl  (dec_leaf_tbl),
        .meta_base (dec_meta_base),
        .attr      (dec_attr),
        .tile_bad  (dec_tile_bad)
    );

    logic in_wait;
    logic take;
    logic accept;

    assign in_wait = (state_q == ST_WAIT_TOP) || (state_q == ST_WAIT_MID) ||
                     (state_q == ST_WAIT_LEAF);
    assign take    = in_wait && rd_rsp_valid && !invalidate;
    assign accept  = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_ISSUE_TOP;
            end
            ST_ISSUE_TOP: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_req_ready) state_d = ST_WAIT_TOP;
            end
            ST_WAIT_TOP: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_rsp_valid) state_d = dec_present ? ST_ISSUE_MID : ST_REPLY;
            end
            ST_ISSUE_MID: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_req_ready) state_d = ST_WAIT_MID;
            end
            ST_WAIT_MID: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_rsp_valid) state_d = dec_present ? ST_ISSUE_LEAF : ST_REPLY;
            end
            ST_ISSUE_LEAF: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_req_ready) state_d = ST_WAIT_LEAF;
            end
            ST_WAIT_LEAF: begin
                if (invalidate)        state_d = ST_IDLE;
                else if (rd_rsp_valid) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                if (invalidate || rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context, drain flag and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q     <= '0;
            va_q       <= '0;
            coarse_q   <= 1'b0;
            tbl_ptr_q  <= '0;
            drop_q     <= 1'b0;
            meta_q     <= '0;
            fault_q    <= 1'b0;
            attr_err_q <= 1'b0;
            attr_q     <= '0;
        end else begin
            if (root_wr) root_q <= root_wdata;

            if (state_q == ST_IDLE && accept) begin
                va_q      <= req_va;
                coarse_q  <= mode_coarse;
                tbl_ptr_q <= root_q;
            end

            if (in_wait && invalidate) begin
                drop_q <= !rd_rsp_valid;
            end else if (state_q == ST_IDLE && drop_q && rd_rsp_valid) begin
                drop_q <= 1'b0;
            end

            if (take && !dec_present) begin
                meta_q     <= '0;
                fault_q    <= 1'b1;
                attr_err_q <= 1'b0;
                attr_q     <= '0;
            end else if (take) begin
                unique case (state_q)
                    ST_WAIT_TOP: tbl_ptr_q <= dec_mid_tbl;
                    ST_WAIT_MID: tbl_ptr_q <= dec_leaf_tbl;
                    ST_WAIT_LEAF: begin
                        meta_q     <= dec_meta_base + meta_off;
                        fault_q    <= 1'b0;
                        attr_err_q <= dec_tile_bad;
                        attr_q     <= dec_attr;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        lvl          = LVL_LEAF;
        rd_req_valid = 1'b0;
        rd_rsp_ready = 1'b0;
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready    = !drop_q && !invalidate;
                rd_rsp_ready = drop_q;
            end
            ST_ISSUE_TOP: begin
                lvl          = LVL_TOP;
                rd_req_valid = !invalidate;
            end
            ST_ISSUE_MID: begin
                lvl          = LVL_MID;
                rd_req_valid = !invalidate;
            end
            ST_ISSUE_LEAF: begin
                lvl          = LVL_LEAF;
                rd_req_valid = !invalidate;
            end
            ST_WAIT_TOP, ST_WAIT_MID, ST_WAIT_LEAF: begin
                rd_rsp_ready = 1'b1;
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign rsp_meta_addr = meta_q;
    assign rsp_fault     = fault_q;
    assign rsp_attr_err  = attr_err_q;
    assign rsp_format    = attr_q.fmt;
    assign rsp_chroma    = attr_q.chroma;
    assign rsp_depth     = attr_q.depth;
    assign rsp_tile      = attr_q.tile;
endmodule

// File: rtl/meta_table_walker_chk.sv
module meta_table_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        invalidate,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [47:0] rsp_meta_addr,
    input logic        rsp_fault,
    input logic        rsp_attr_err,
    input logic [5:0]  rsp_format,
    input logic        rsp_chroma,
    input logic [2:0]  rsp_depth,
    input logic [1:0]  rsp_tile,
    input logic        rd_req_valid,
    input logic        rd_req_ready,
    input logic [47:0] rd_req_addr,
    input logic        rd_rsp_ready
);
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready && !invalidate |=> rd_req_valid && $stable(rd_req_addr));

    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !rd_rsp_ready);

    a_r8_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready && !invalidate |=> rsp_valid &&
        $stable({rsp_meta_addr, rsp_fault, rsp_attr_err, rsp_format, rsp_chroma, rsp_depth, rsp_tile}));

    a_r4_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_meta_addr == 48'd0 && !rsp_attr_err);

    a_r7_attr_err_tile: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_attr_err |-> rsp_tile[1]);

    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !rsp_valid && !rd_req_valid);
endmodule

bind meta_table_walker meta_table_walker_chk u_chk (.*);

// File: tb/test_meta_table_walker.sv
`timescale 1ns/1ps
module test_meta_table_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_coarse = 1'b0;
    logic        root_wr = 1'b0;
    logic [47:0] root_wdata = '0;
    logic        inv_tb = 1'b0;
    logic        inv_model = 1'b0;
    logic        invalidate;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [47:0] rsp_meta_addr;
    logic        rsp_fault, rsp_attr_err, rsp_chroma;
    logic [5:0]  rsp_format;
    logic [2:0]  rsp_depth;
    logic [1:0]  rsp_tile;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [47:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic        rd_rsp_ready;
    logic [63:0] rd_rsp_data = '0;

    assign invalidate = inv_tb | inv_model;

    always #2.5 clk = ~clk;

    meta_table_walker i_meta_table_walker (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    localparam logic [47:0] ROOT_A = 48'h0000_0010_0000;
    localparam logic [47:0] ROOT_B = 48'h0000_0040_0000;
    localparam logic [47:0] NO_ARM = 48'hFFFF_FFFF_FFFF;

    function automatic logic [63:0] mem_lookup(input logic [47:0] a);
        case (a)
            48'h0000_0010_0028: return 64'hABCD_0000_0020_7FFF;
            48'h0000_0040_0028: return 64'h0000_0000_0020_0001;
            48'h0000_0020_0018: return 64'h0000_0000_0030_1FFF;
            48'h0000_0030_0228: return 64'hAB50_0000_0ABC_DEFF;
            48'h0000_0030_0020: return 64'h0CE0_0000_5000_0001;
            48'h0000_0030_0238: return 64'hAB50_0000_0ABC_DE00;
            default:            return 64'h0;
        endcase
    endfunction

    int          lat = 0;
    bit          stall = 1'b0;
    logic [47:0] arm_acc = NO_ARM;
    logic [47:0] arm_rsp = NO_ARM;
    int          total_reads = 0;
    logic [47:0] rd_log [16];
    int          rsp_seen = 0;

    initial begin
        bit          pend = 0;
        bit          drv = 0;
        bit          acc_inv = 0;
        int          cnt = 0;
        int          cyc = 0;
        logic [47:0] paddr = '0;
        forever begin
            @(negedge clk);
            #0.5;
            cyc++;
            inv_model = acc_inv;
            acc_inv = 0;
            if (drv) begin
                rd_rsp_valid = 1'b0;
                drv = 0;
            end
            if (pend) begin
                if (cnt > 0) cnt--;
                else if (rd_rsp_ready) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem_lookup(paddr);
                    pend = 0;
                    drv = 1;
                    if (paddr == arm_rsp) inv_model = 1'b1;
                end
            end
            rd_req_ready = stall ? cyc[0] : 1'b1;
            #0.1;
            if (rd_req_valid && rd_req_ready) begin
                pend = 1;
                paddr = rd_req_addr;
                cnt = lat;
                rd_log[total_reads % 16] = rd_req_addr;
                total_reads++;
                if (rd_req_addr == arm_acc) acc_inv = 1;
            end
            if (rsp_valid) rsp_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(input logic m, input logic [47:0] va);
        @(negedge clk);
        mode_coarse = m;
        req_va      = va;
        req_valid   = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid   = 1'b0;
        mode_coarse = ~m;   // R3: must not affect the walk already accepted
    endtask

    task automatic wait_rsp(output bit got);
        got = 0;
        for (int i = 0; i < 300 && !got; i++) begin
            @(negedge clk);
            #1;
            if (rsp_valid) got = 1;
        end
    endtask

    typedef struct packed {
        logic        mode;
        logic [47:0] va;
        logic        fault;
        logic [47:0] meta;
        logic        aerr;
        logic [1:0]  nreads;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 48'h0050_0345_6789, 1'b0, 48'h0000_0ABC_DE67, 1'b0, 2'd3},
        '{1'b1, 48'h0050_0345_6789, 1'b0, 48'h0000_5000_0567, 1'b1, 2'd3},
        '{1'b0, 48'h0060_0000_0000, 1'b1, 48'h0,              1'b0, 2'd1},
        '{1'b0, 48'h0050_0400_0000, 1'b1, 48'h0,              1'b0, 2'd2},
        '{1'b0, 48'h0050_0346_0000, 1'b1, 48'h0,              1'b0, 2'd3},
        '{1'b0, 48'h0050_0347_FFFF, 1'b1, 48'h0,              1'b0, 2'd3},
        '{1'b1, 48'h0050_034F_FFFF, 1'b0, 48'h0000_5000_0FFF, 1'b1, 2'd3},
        '{1'b0, 48'h0050_0345_FFFF, 1'b0, 48'h0000_0ABC_DEFF, 1'b0, 2'd3}
    };

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit got;
        int base;
        int seen0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R8 reset rd_req_valid", 64'(rd_req_valid), 64'd0);
        check("R8 reset req_ready", 64'(req_ready), 64'd1);

        // R12: load the root register
        @(negedge clk);
        root_wr = 1'b1; root_wdata = ROOT_A;
        @(negedge clk);
        root_wr = 1'b0;

        // Vector table, two passes: no stall, then stalled memory
        for (int pass = 0; pass < 2; pass++) begin
            stall = (pass == 1);
            lat   = (pass == 1) ? 3 : 0;
            for (int v = 0; v < NVEC; v++) begin
                base = total_reads;
                issue(VEC[v].mode, VEC[v].va);
                wait_rsp(got);
                check("R10 response arrives", 64'(got), 64'd1);
                check("R4 fault flag", 64'(rsp_fault), 64'(VEC[v].fault));
                check("R5 metadata address", 64'(rsp_meta_addr), 64'(VEC[v].meta));
                check("R7 attribute error", 64'(rsp_attr_err), 64'(VEC[v].aerr));
                @(negedge clk);
                check("R4 R8 read count", 64'(total_reads - base), 64'(VEC[v].nreads));
                check("R1 top entry address", 64'(rd_log[base % 16]),
                      64'(ROOT_A + {33'd0, VEC[v].va[47:36], 3'b000}));
            end
        end
        stall = 1'b0;
        lat   = 0;

        // R6 / R2: attributes of both leaves, masked pointer bits
        base = total_reads;
        issue(1'b0, VEC[0].va);
        wait_rsp(got);
        check("R6 format", 64'(rsp_format), 64'h2A);
        check("R6 chroma", 64'(rsp_chroma), 64'd1);
        check("R6 depth", 64'(rsp_depth), 64'd5);
        check("R6 tile", 64'(rsp_tile), 64'd1);
        @(negedge clk);
        check("R2 mid entry address", 64'(rd_log[(base + 1) % 16]), 64'h20_0018);
        check("R3 fine leaf entry address", 64'(rd_log[(base + 2) % 16]), 64'h30_0228);

        base = total_reads;
        issue(1'b1, VEC[1].va);
        wait_rsp(got);
        check("R6 coarse format", 64'(rsp_format), 64'h03);
        check("R6 coarse chroma", 64'(rsp_chroma), 64'd0);
        check("R6 coarse depth", 64'(rsp_depth), 64'd3);
        check("R7 reserved tile", 64'(rsp_tile), 64'd2);
        @(negedge clk);
        check("R3 coarse leaf entry address", 64'(rd_log[(base + 2) % 16]), 64'h30_0020);

        // R12: new root, and write during a walk does not disturb it
        @(negedge clk);
        root_wr = 1'b1; root_wdata = ROOT_B;
        @(negedge clk);
        root_wr = 1'b0;
        base = total_reads;
        issue(1'b0, VEC[0].va);
        root_wr = 1'b1; root_wdata = 48'h0000_0070_0000;
        @(negedge clk);
        root_wr = 1'b0;
        wait_rsp(got);
        check("R12 walk via new root", 64'(rsp_meta_addr), 64'h0ABC_DE67);
        @(negedge clk);
        check("R12 top read at new root", 64'(rd_log[base % 16]), 64'h40_0028);
        @(negedge clk);
        root_wr = 1'b1; root_wdata = ROOT_A;
        @(negedge clk);
        root_wr = 1'b0;

        // R9: response held while rsp_ready is low
        rsp_ready = 1'b0;
        issue(1'b0, VEC[0].va);
        wait_rsp(got);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            check("R9 rsp_valid held", 64'(rsp_valid), 64'd1);
            check("R9 meta held", 64'(rsp_meta_addr), 64'h0ABC_DE67);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        #1;
        check("R9 released after ready", 64'(rsp_valid), 64'd0);

        // R10: invalidate discards a held response
        rsp_ready = 1'b0;
        issue(1'b0, VEC[0].va);
        wait_rsp(got);
        @(negedge clk);
        inv_tb = 1'b1;
        @(negedge clk);
        inv_tb = 1'b0;
        #1;
        check("R10 held response dropped", 64'(rsp_valid), 64'd0);
        rsp_ready = 1'b1;

        // R10: invalidate in the same cycle as the leaf data
        arm_rsp = 48'h0000_0030_0228;
        base = total_reads;
        issue(1'b0, VEC[0].va);
        seen0 = rsp_seen;
        repeat (25) @(negedge clk);
        #1;
        check("R10 no response on coincident abort", 64'(rsp_seen - seen0), 64'd0);
        check("R10 walk reached leaf before abort", 64'(total_reads - base), 64'd3);
        check("R10 idle after coincident abort", 64'(req_ready), 64'd1);
        arm_rsp = NO_ARM;

        // R11: abort with a read still outstanding, then drain
        lat = 6;
        arm_acc = 48'h0000_0020_0018;
        issue(1'b0, VEC[0].va);
        seen0 = rsp_seen;
        for (int i = 0; i < 40 && !inv_model; i++) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        #1;
        check("R11 req_ready low while draining", 64'(req_ready), 64'd0);
        check("R11 drain accepts stale data", 64'(rd_rsp_ready), 64'd1);
        arm_acc = NO_ARM;
        for (int i = 0; i < 40 && !req_ready; i++) begin
            @(negedge clk);
            #1;
        end
        check("R11 ready after drain", 64'(req_ready), 64'd1);
        check("R11 no response from aborted walk", 64'(rsp_seen - seen0), 64'd0);
        lat = 1;
        base = total_reads;
        issue(1'b0, VEC[0].va);
        wait_rsp(got);
        check("R11 next walk meta", 64'(rsp_meta_addr), 64'h0ABC_DE67);
        check("R11 next walk fault", 64'(rsp_fault), 64'd0);
        @(negedge clk);
        check("R11 next walk reads", 64'(total_reads - base), 64'd3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule